// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides, in the digital domain, whether a phase-locked loop has settled. It is clocked by a fast sampling clock. Each phase detector cycle shows up as two single-tick pulses, one from the reference path and one from the feedback path. The block counts the sampling-clock ticks between the two pulses, whichever comes first. It then compares that count with a tick threshold. The threshold comes from one of two window widths, converted at elaboration time using the sampling-clock period.

A run of consecutive in-window detector cycles raises the lock flag. The length of that run is set by one select bit, and a second select bit picks the window. One bad cycle drops the flag and starts the run again from zero. A bad cycle is one whose difference is too wide, whose partner pulse never arrives, or whose first pulse repeats before its partner arrives. Power-down and counter reset both hold the detector cleared. A change to either select bit also restarts qualification. Analog phase detection and the charge pump are outside this block.

Top module: `pll_lock_detect`

## Requirements
- R1: While rst_n is low, and after it is released, locked reads 0 until a full qualifying run has been seen.
- R2: The edge difference of a detector cycle is the number of sampling-clock ticks from the first pulse to the second. The order of the pulses does not matter. Pulses on ref_edge and fb_edge in the same tick give a difference of 0.
- R3: A cycle qualifies when its difference is at or below the selected threshold. With win_sel=0 the window is 10 ns, which is 10 ticks at the default 1000 ps period. With win_sel=1 the window is 6 ns, which is 6 ticks.
- R4: With cnt_sel=0, locked rises after 40 consecutive qualifying cycles. With cnt_sel=1, it rises after 5. In both cases locked goes high two clocks after the second pulse of the last cycle in the run, and not one cycle earlier.
- R5: Once locked, further qualifying cycles keep locked high.
- R6: A cycle whose difference exceeds the threshold clears the run and drops locked two clocks after its second pulse.
- R7: If the opposite pulse does not arrive within TIMEOUT_TICKS ticks (64 by default) of the first, the cycle counts as failing. The detector then waits for a fresh first pulse.
- R8: If the same pulse as the first arrives again before the opposite one, the pending cycle counts as failing. The repeated pulse then starts a new measurement.
- R9: While pwr_dn or cnt_rst is high, locked is 0, the run is cleared, and pulses are ignored.
- R10: A change of cnt_sel or win_sel clears the run and drops locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; clears and holds the detector |
| cnt_rst | input | 1 | Counter reset; clears and holds the detector |
| ref_edge | input | 1 | Single-tick reference edge pulse |
| fb_edge | input | 1 | Single-tick feedback edge pulse |
| cnt_sel | input | 1 | Run length select: 0 = 40 cycles, 1 = 5 cycles |
| win_sel | input | 1 | Window select: 0 = 10 ns, 1 = 6 ns |
| locked | output | 1 | Lock indication |

## Verification
The hardest case to reach is a repeated first pulse arriving while a measurement is pending. It has to fail the old cycle and also start a valid new one. The stimulus first reaches lock in the short mode. It then sends a reference pulse, a second reference pulse three ticks later, and a feedback pulse two ticks after that. The bench then confirms that lock dropped. It also confirms that exactly four more good cycles restore lock, which is only possible if the second pair was counted.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_WAIT = 1'b1
   } tmr_state_e;

   typedef struct packed {
      logic valid;
      logic ok;
   } meas_t;
endpackage

// File: rtl/lkd_edge_timer.sv
module lkd_edge_timer
   import lkd_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 64,
   parameter int THR_W         = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ref_edge,
   input  logic             fb_edge,
   input  logic [THR_W-1:0] thr,
   output meas_t            meas
);
   localparam int TW = $clog2(TIMEOUT_TICKS + 1);
   localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_TICKS - 1);

   tmr_state_e    state;
   logic          first_ref;
   logic [TW-1:0] cnt;
   logic          other_hit;
   logic          same_hit;

   always_comb begin
      other_hit = first_ref ? fb_edge  : ref_edge;
      same_hit  = first_ref ? ref_edge : fb_edge;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TMR_IDLE;
         first_ref <= 1'b0;
         cnt       <= '0;
         meas      <= '0;
      end else if (clr) begin
         state     <= TMR_IDLE;
         cnt       <= '0;
         meas      <= '0;
      end else begin
         meas.valid <= 1'b0;
         case (state)
            TMR_IDLE: begin
               if (ref_edge && fb_edge) begin
                  meas <= '{valid: 1'b1, ok: 1'b1};
               end else if (ref_edge || fb_edge) begin
                  state     <= TMR_WAIT;
                  first_ref <= ref_edge;
                  cnt       <= '0;
               end
            end
            default: begin
               if (other_hit) begin
                  // difference is cnt+1 ticks; qualifies when cnt+1 <= thr
                  meas  <= '{valid: 1'b1, ok: (32'(cnt) < 32'(thr))};
                  state <= TMR_IDLE;
               end else if (same_hit) begin
                  meas <= '{valid: 1'b1, ok: 1'b0};
                  cnt  <= '0;
               end else if (cnt == TO_LAST) begin
                  meas  <= '{valid: 1'b1, ok: 1'b0};
                  state <= TMR_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   // R7: a pending measurement never runs past the timeout
   a_r7_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TMR_WAIT) |-> (32'(cnt) < TIMEOUT_TICKS));

   // R8: a repeated first pulse yields a failing result
   a_r8_repeat_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && state == TMR_WAIT && same_hit && !other_hit) |=> (meas.valid && !meas.ok));
endmodule

// File: rtl/lkd_qual_counter.sv
module lkd_qual_counter
   import lkd_pkg::*;
#(
   parameter int CNT_LONG  = 40,
   parameter int CNT_SHORT = 5
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  cnt_sel,
   input  logic  win_sel,
   input  meas_t meas,
   output logic  locked
);
   localparam int CNT_MAX = (CNT_LONG > CNT_SHORT) ? CNT_LONG : CNT_SHORT;
   localparam int QW      = $clog2(CNT_MAX + 1);

   logic [QW-1:0] run;
   logic [QW-1:0] run_nxt;
   logic [QW-1:0] target;
   logic [1:0]    sel_q;
   logic          sel_chg;

   always_comb begin
      target  = cnt_sel ? QW'(CNT_SHORT) : QW'(CNT_LONG);
      sel_chg = ({cnt_sel, win_sel} != sel_q);
      run_nxt = (run >= target) ? run : run + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= '0;
         locked <= 1'b0;
         sel_q  <= 2'b00;
      end else begin
         sel_q <= {cnt_sel, win_sel};
         if (clr || sel_chg) begin
            run    <= '0;
            locked <= 1'b0;
         end else if (meas.valid) begin
            if (meas.ok) begin
               run    <= run_nxt;
               locked <= (run_nxt >= target);
            end else begin
               run    <= '0;
               locked <= 1'b0;
            end
         end
      end
   end

   // R4: lock only rises on the back of a qualifying result
   a_r4_rise_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(meas.valid && meas.ok));

   // R6: a failing result drops lock
   a_r6_fail_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (meas.valid && !meas.ok) |=> !locked);

   // R9: clear holds the detector empty
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!locked && run == '0));

   // R10: select change restarts qualification
   a_r10_sel_change: assert property (@(posedge clk) disable iff (!rst_n)
      sel_chg |=> (!locked && run == '0));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
   import lkd_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 1000,
   parameter int WIN_WIDE_PS   = 10000,
   parameter int WIN_NARROW_PS = 6000,
   parameter int CNT_LONG      = 40,
   parameter int CNT_SHORT     = 5,
   parameter int TIMEOUT_TICKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_dn,
   input  logic cnt_rst,
   input  logic ref_edge,
   input  logic fb_edge,
   input  logic cnt_sel,
   input  logic win_sel,
   output logic locked
);
   localparam int WIDE_TICKS   = WIN_WIDE_PS / CLK_PERIOD_PS;
   localparam int NARROW_TICKS = WIN_NARROW_PS / CLK_PERIOD_PS;
   localparam int THR_W        = $clog2(TIMEOUT_TICKS + 1);

   if (CLK_PERIOD_PS < 1)              $error("CLK_PERIOD_PS must be positive");
   if (NARROW_TICKS < 1)               $error("narrow window under one tick");
   if (WIDE_TICKS >= TIMEOUT_TICKS)    $error("timeout must exceed the wide window");
   if (CNT_LONG < 1 || CNT_SHORT < 1)  $error("run lengths must be at least 1");

   logic [THR_W-1:0] thr_tbl [2];
   for (genvar gi = 0; gi < 2; gi++) begin : g_thr
      assign thr_tbl[gi] = (gi == 0) ? THR_W'(WIDE_TICKS) : THR_W'(NARROW_TICKS);
   end

   logic  clr;
   meas_t meas;

   assign clr = pwr_dn | cnt_rst;

   lkd_edge_timer #(
      .TIMEOUT_TICKS(TIMEOUT_TICKS),
      .THR_W        (THR_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .ref_edge(ref_edge),
      .fb_edge (fb_edge),
      .thr     (thr_tbl[win_sel]),
      .meas    (meas)
   );

   lkd_qual_counter #(
      .CNT_LONG (CNT_LONG),
      .CNT_SHORT(CNT_SHORT)
   ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .cnt_sel(cnt_sel),
      .win_sel(win_sel),
      .meas   (meas),
      .locked (locked)
   );

   // R1: reset leaves lock low
   a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !locked);
endmodule

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b0, cnt_rst = 1'b0;
   logic ref_edge = 1'b0, fb_edge = 1'b0;
   logic cnt_sel = 1'b1, win_sel = 1'b0;
   logic locked;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_lock_detect u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .cnt_rst(cnt_rst),
      .ref_edge(ref_edge), .fb_edge(fb_edge),
      .cnt_sel(cnt_sel), .win_sel(win_sel), .locked(locked)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: locked=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // one detector cycle: first pulse, then the other 'gap' ticks later
   task automatic pair(input bit ref_first, input int gap);
      @(negedge clk);
      if (gap == 0) begin
         ref_edge = 1'b1; fb_edge = 1'b1;
      end else if (ref_first) ref_edge = 1'b1;
      else fb_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0;
      if (gap > 0) begin
         repeat (gap - 1) @(negedge clk);
         if (ref_first) fb_edge = 1'b1; else ref_edge = 1'b1;
         @(negedge clk);
         ref_edge = 1'b0; fb_edge = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_ref();
      @(negedge clk); ref_edge = 1'b1;
      @(negedge clk); ref_edge = 1'b0;
   endtask

   task automatic clear_state();
      @(negedge clk); cnt_rst = 1'b1;
      repeat (2) @(negedge clk); cnt_rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 during reset", locked, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after reset", locked, 1'b0);
   endtask

   task automatic t_short_run();
      clear_state();
      for (int i = 0; i < 4; i++) pair(1'b1, 3);
      check("R4 short run not yet", locked, 1'b0);
      pair(1'b0, 2);  // feedback first, R2
      check("R4 short run locks", locked, 1'b1);
      pair(1'b1, 0);  // same tick, R2
      check("R5 lock held", locked, 1'b1);
   endtask

   task automatic t_lock_timing();
      clear_state();
      for (int i = 0; i < 4; i++) pair(1'b1, 1);
      @(negedge clk); ref_edge = 1'b1;
      @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b1;
      @(negedge clk); fb_edge = 1'b0;
      check("R4 lock not one clock early", locked, 1'b0);
      @(negedge clk);
      check("R4 lock two clocks after edge", locked, 1'b1);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_wide_window();
      clear_state();
      win_sel = 1'b0;
      clear_state();
      for (int i = 0; i < 5; i++) pair(1'b1, 10);
      check("R3 wide window 10 ticks ok", locked, 1'b1);
      pair(1'b0, 11);
      check("R6 wide window 11 ticks fails", locked, 1'b0);
   endtask

   task automatic t_narrow_window();
      win_sel = 1'b1;
      clear_state();
      for (int i = 0; i < 5; i++) pair(1'b0, 6);
      check("R3 narrow window 6 ticks ok", locked, 1'b1);
      pair(1'b1, 7);
      check("R6 narrow window 7 ticks fails", locked, 1'b0);
      for (int i = 0; i < 4; i++) pair(1'b1, 6);
      check("R6 run restarted after fail", locked, 1'b0);
      pair(1'b1, 6);
      check("R6 relock after fresh run", locked, 1'b1);
      win_sel = 1'b0;
   endtask

   task automatic t_long_run();
      cnt_sel = 1'b0;
      clear_state();
      for (int i = 0; i < 39; i++) pair(1'b1, 4);
      check("R4 long run 39 not locked", locked, 1'b0);
      pair(1'b1, 4);
      check("R4 long run 40 locks", locked, 1'b1);
      cnt_sel = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 cnt_sel change drops lock", locked, 1'b0);
   endtask

   task automatic t_timeout();
      clear_state();
      for (int i = 0; i < 5; i++) pair(1'b1, 2);
      check("R7 locked before timeout", locked, 1'b1);
      pulse_ref();
      repeat (70) @(negedge clk);
      check("R7 missing edge fails", locked, 1'b0);
      for (int i = 0; i < 5; i++) pair(1'b1, 2);
      check("R7 recovers after timeout", locked, 1'b1);
   endtask

   task automatic t_repeat_edge();
      clear_state();
      for (int i = 0; i < 5; i++) pair(1'b1, 2);
      pulse_ref();
      @(negedge clk);
      pair(1'b1, 2);
      check("R8 repeated edge drops lock", locked, 1'b0);
      for (int i = 0; i < 3; i++) pair(1'b1, 2);
      check("R8 three more not enough", locked, 1'b0);
      pair(1'b1, 2);
      check("R8 second pair counted", locked, 1'b1);
   endtask

   task automatic t_clear_inputs();
      for (int i = 0; i < 5; i++) pair(1'b1, 1);
      @(negedge clk); pwr_dn = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 power-down drops lock", locked, 1'b0);
      for (int i = 0; i < 6; i++) pair(1'b1, 1);
      check("R9 pulses ignored in power-down", locked, 1'b0);
      pwr_dn = 1'b0;
      for (int i = 0; i < 4; i++) pair(1'b1, 1);
      check("R9 run cleared by power-down", locked, 1'b0);
      pair(1'b1, 1);
      @(negedge clk); cnt_rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 counter reset drops lock", locked, 1'b0);
      cnt_rst = 1'b0;
   endtask

   task automatic t_win_change();
      clear_state();
      for (int i = 0; i < 5; i++) pair(1'b1, 2);
      @(negedge clk); win_sel = ~win_sel;
      repeat (2) @(negedge clk);
      check("R10 win_sel change drops lock", locked, 1'b0);
      for (int i = 0; i < 4; i++) pair(1'b1, 2);
      check("R10 run restarted", locked, 1'b0);
      win_sel = 1'b0;
   endtask

   initial begin
      t_reset();
      t_short_run();
      t_lock_timing();
      t_wide_window();
      t_narrow_window();
      t_long_run();
      t_timeout();
      t_repeat_edge();
      t_clear_inputs();
      t_win_change();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule